// File: doc/BRIEF.md
# 1-Wire Bridge Command Processor

This block sits between a host that delivers bytes one at a time and a bit-level 1-Wire engine. The host presents a byte with a one-cycle valid strobe; the first byte of a transaction is an opcode, and some opcodes take exactly one parameter byte after it. The processor decodes a fixed set of eight opcodes. It holds a configuration nibble, a read-data byte, a status byte and a read pointer. The host always sees the register that the pointer selects on a combinational read-data return.

Bus operations are bus reset, single bit, byte write, byte read and search triplet. Each is carried out as one or more engine operations through a request pulse and a done pulse. A triplet is built from three single-bit engine operations: two read slots, then one write slot. The direction written in the third slot is resolved inside the block from the two bits read back. While an operation runs, the status busy bit is set and the host polls it. Bus timing, the pull-up drivers and the physical host link are not part of the block.

Top module: `owb_cmd_proc`

## Requirements
- R1: After synchronous reset the pointer selects status and the configuration is 0. The status byte reads 0x10 when bus_level is 0. Status layout: bit0 busy, bit1 presence, bit2 short, bit3 bus level, bit4 reset flag, bit5 single-bit result, bit6 triplet second bit, bit7 chosen direction.
- R2: Opcode 0xF0 clears the configuration and status bits 1, 2, 5, 6 and 7. It sets the reset flag and selects status. The next accepted command clears the reset flag.
- R3: Opcode 0xE1 followed by 0xF0, 0xE1 or 0xC3 selects status, read data or configuration. Any other code leaves the pointer unchanged.
- R4: Opcode 0xD2 with parameter p is accepted only when p[7:4] equals the complement of p[3:0]. It then stores p[3:0] and selects configuration. Otherwise the configuration and pointer keep their values. Configuration bit0 drives cfg_active_pullup, bit2 cfg_strong_pullup and bit3 cfg_high_speed.
- R5: The busy bit is 1 from the cycle after a bus opcode is accepted until the final engine done of that operation is taken. At most one engine request is outstanding at a time.
- R6: Opcode 0xB4 issues one engine operation with code 0 (bus reset). At done, eng_presence is stored in status bit1 and eng_short in status bit2.
- R7: Opcode 0x87 with parameter p issues one operation with code 1 (bit slot) and eng_wdata[0] = p[7]. At done, eng_rbit is stored in status bit5 and bits 6 and 7 are cleared.
- R8: Opcode 0xA5 with parameter p issues one operation with code 2 and eng_wdata = p.
- R9: Opcode 0x96 issues one operation with code 3. At done, eng_rbyte is stored in the read-data register and the pointer moves to read data one cycle later.
- R10: Opcode 0x78 with parameter p issues three bit-slot operations. The first two write 1 and return a then b; the third writes direction d. d is a when a and b differ, p[7] when both are 0, and 1 when both are 1. Status bits 5, 6 and 7 become a, b and d.
- R11: While busy, only opcode 0xE1 is accepted and other bytes are dropped. A byte arriving on the edge where the final done is taken is still dropped. Unknown opcodes are dropped without taking a parameter.
- R12: Status bit3 follows bus_level in the same cycle.
- R13: Accepting a bus opcode selects status. When a pointer code is accepted on the same edge as a stored read byte's pointer move, the host's code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host byte strobe |
| host_byte | input | 8 | Host opcode or parameter byte |
| host_rdata | output | 8 | Register selected by the pointer |
| eng_req | output | 1 | One-cycle engine request |
| eng_op | output | 2 | Engine operation code |
| eng_wdata | output | 8 | Byte to write, or bit value in bit0 |
| eng_done | input | 1 | Engine completion pulse |
| eng_rbit | input | 1 | Bit read in a bit slot |
| eng_rbyte | input | 8 | Byte read by a read-byte operation |
| eng_presence | input | 1 | Presence seen after bus reset |
| eng_short | input | 1 | Short seen after bus reset |
| bus_level | input | 1 | Present bus line level |
| cfg_active_pullup | output | 1 | Configuration bit0 |
| cfg_strong_pullup | output | 1 | Configuration bit2 |
| cfg_high_speed | output | 1 | Configuration bit3 |

## Verification
The read-byte completion and the host's set-pointer command can both move the read pointer on the same edge. The bench provokes this by sending the pointer parameter in the exact cycle the stored byte's pointer move is due. It then judges that the host's code wins and that the byte was still captured. A second collision, a host byte arriving on the edge where the engine's final done is taken, is timed the same way. It is judged by the configuration staying unchanged, while a byte sent one cycle later is accepted.

// File: rtl/owb_pkg.sv
// Package: shared constants, types and helper functions for the 1-Wire
// bridge command processor. Assumes byte-wide host traffic.
package owb_pkg;

    localparam int BYTE_W = 8;
    localparam int CFG_W  = 4;
    localparam int NIB_W  = BYTE_W / 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // host opcodes
    localparam byte_t OPC_DEVRST = 8'hF0;
    localparam byte_t OPC_SETPTR = 8'hE1;
    localparam byte_t OPC_WCFG   = 8'hD2;
    localparam byte_t OPC_BUSRST = 8'hB4;
    localparam byte_t OPC_BIT    = 8'h87;
    localparam byte_t OPC_WBYTE  = 8'hA5;
    localparam byte_t OPC_RBYTE  = 8'h96;
    localparam byte_t OPC_TRIP   = 8'h78;

    // read pointer selection codes
    localparam byte_t SEL_STATUS = 8'hF0;
    localparam byte_t SEL_DATA   = 8'hE1;
    localparam byte_t SEL_CFG    = 8'hC3;

    typedef enum logic [3:0] {
        K_NONE, K_DEVRST, K_SETPTR, K_WCFG, K_BUSRST,
        K_BIT, K_WBYTE, K_RBYTE, K_TRIP
    } cmd_kind_e;

    typedef enum logic [1:0] {
        EOP_RESET = 2'd0, EOP_BIT = 2'd1, EOP_WBYTE = 2'd2, EOP_RBYTE = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {RP_STATUS, RP_DATA, RP_CFG} rdptr_e;

    typedef struct packed {
        logic      vld;
        cmd_kind_e kind;
        byte_t     prm;
    } cmd_t;

    function automatic cmd_kind_e decode_opcode(input byte_t b);
        cmd_kind_e k;
        case (b)
            OPC_DEVRST: k = K_DEVRST;
            OPC_SETPTR: k = K_SETPTR;
            OPC_WCFG:   k = K_WCFG;
            OPC_BUSRST: k = K_BUSRST;
            OPC_BIT:    k = K_BIT;
            OPC_WBYTE:  k = K_WBYTE;
            OPC_RBYTE:  k = K_RBYTE;
            OPC_TRIP:   k = K_TRIP;
            default:    k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic needs_param(input cmd_kind_e k);
        return (k == K_SETPTR) || (k == K_WCFG) || (k == K_BIT) ||
               (k == K_WBYTE) || (k == K_TRIP);
    endfunction

    function automatic logic is_bus_cmd(input cmd_kind_e k);
        return (k == K_BUSRST) || (k == K_BIT) || (k == K_WBYTE) ||
               (k == K_RBYTE) || (k == K_TRIP);
    endfunction

    function automatic logic cfg_ok(input byte_t p);
        return p[BYTE_W-1:NIB_W] == ~p[NIB_W-1:0];
    endfunction

    // direction resolution for a search triplet
    function automatic logic tri_dir(input logic a, input logic b, input logic pref);
        if (a != b) return a;
        else if (!a) return pref;
        else return 1'b1;
    endfunction

endpackage

// File: rtl/owb_host_decoder.sv
// Host byte decoder: frames opcode and parameter bytes and emits one
// decoded command pulse per complete command. Assumes host_valid is a
// one-cycle strobe. Drops unknown opcodes, and drops every opcode except
// set-pointer while the bus sequencer is busy.
module owb_host_decoder
    import owb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  byte_t in_byte,
    input  logic  busy,
    output cmd_t  cmd_o
);

    typedef enum logic {D_OPCODE, D_PARAM} dstate_e;

    dstate_e   state_q;
    cmd_kind_e held_q;
    cmd_kind_e kind_in;
    logic      take_op;

    // classify the incoming byte as an opcode
    always_comb begin
        kind_in = decode_opcode(in_byte);
        take_op = (state_q == D_OPCODE) && in_valid && (kind_in != K_NONE) &&
                  (!busy || kind_in == K_SETPTR);
    end

    // emit a complete command in the cycle its last byte arrives
    always_comb begin
        cmd_o.vld  = 1'b0;
        cmd_o.kind = K_NONE;
        cmd_o.prm  = '0;
        if (state_q == D_PARAM && in_valid) begin
            cmd_o.vld  = 1'b1;
            cmd_o.kind = held_q;
            cmd_o.prm  = in_byte;
        end else if (take_op && !needs_param(kind_in)) begin
            cmd_o.vld  = 1'b1;
            cmd_o.kind = kind_in;
        end
    end

    // track whether the next byte is an opcode or a parameter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= D_OPCODE;
            held_q  <= K_NONE;
        end else if (state_q == D_PARAM && in_valid) begin
            state_q <= D_OPCODE;
        end else if (take_op && needs_param(kind_in)) begin
            state_q <= D_PARAM;
            held_q  <= kind_in;
        end
    end

    AST_BUS_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o.vld && is_bus_cmd(cmd_o.kind)) |-> !busy); // R11

endmodule

// File: rtl/owb_bus_sequencer.sv
// Bus sequencer: turns decoded bus commands into engine request/done
// exchanges and keeps the result bits of the status byte. A triplet is
// run as three bit slots with the direction resolved after the second.
// Assumes the engine answers every request with exactly one done pulse.
module owb_bus_sequencer
    import owb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_t       cmd_i,
    output logic       busy_o,
    output logic       eng_req_o,
    output logic [1:0] eng_op_o,
    output byte_t      eng_wdata_o,
    input  logic       eng_done_i,
    input  logic       eng_rbit_i,
    input  byte_t      eng_rbyte_i,
    input  logic       eng_presence_i,
    input  logic       eng_short_i,
    output logic       res_ppd_o,
    output logic       res_sd_o,
    output logic       res_sbr_o,
    output logic       res_tsb_o,
    output logic       res_dir_o,
    output logic       rbyte_vld_o,
    output byte_t      rbyte_o
);

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_RESET, SQ_BIT, SQ_WBYTE, SQ_RBYTE,
        SQ_TRI_A, SQ_TRI_B, SQ_TRI_W
    } sq_state_e;

    localparam byte_t ONES = '1;

    sq_state_e state_q;
    eng_op_e   op_q;
    logic      pref_q;
    logic      first_q;
    logic      dir_now;

    // direction chosen from the first stored bit and the bit now returning
    always_comb dir_now = tri_dir(first_q, eng_rbit_i, pref_q);

    // state machine, engine request and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            op_q        <= EOP_RESET;
            eng_req_o   <= 1'b0;
            eng_wdata_o <= '0;
            pref_q      <= 1'b0;
            first_q     <= 1'b0;
            res_ppd_o   <= 1'b0;
            res_sd_o    <= 1'b0;
            res_sbr_o   <= 1'b0;
            res_tsb_o   <= 1'b0;
            res_dir_o   <= 1'b0;
            rbyte_vld_o <= 1'b0;
            rbyte_o     <= '0;
        end else begin
            eng_req_o   <= 1'b0;
            rbyte_vld_o <= 1'b0;
            if (cmd_i.vld && cmd_i.kind == K_DEVRST) begin
                res_ppd_o <= 1'b0;
                res_sd_o  <= 1'b0;
                res_sbr_o <= 1'b0;
                res_tsb_o <= 1'b0;
                res_dir_o <= 1'b0;
            end
            case (state_q)
                SQ_IDLE: begin
                    if (cmd_i.vld) begin
                        case (cmd_i.kind)
                            K_BUSRST: begin
                                eng_req_o   <= 1'b1;
                                op_q        <= EOP_RESET;
                                eng_wdata_o <= '0;
                                state_q     <= SQ_RESET;
                            end
                            K_BIT: begin
                                eng_req_o   <= 1'b1;
                                op_q        <= EOP_BIT;
                                eng_wdata_o <= {{(BYTE_W-1){1'b0}}, cmd_i.prm[BYTE_W-1]};
                                state_q     <= SQ_BIT;
                            end
                            K_WBYTE: begin
                                eng_req_o   <= 1'b1;
                                op_q        <= EOP_WBYTE;
                                eng_wdata_o <= cmd_i.prm;
                                state_q     <= SQ_WBYTE;
                            end
                            K_RBYTE: begin
                                eng_req_o   <= 1'b1;
                                op_q        <= EOP_RBYTE;
                                eng_wdata_o <= ONES;
                                state_q     <= SQ_RBYTE;
                            end
                            K_TRIP: begin
                                eng_req_o   <= 1'b1;
                                op_q        <= EOP_BIT;
                                eng_wdata_o <= {{(BYTE_W-1){1'b0}}, 1'b1};
                                pref_q      <= cmd_i.prm[BYTE_W-1];
                                state_q     <= SQ_TRI_A;
                            end
                            default: ;
                        endcase
                    end
                end
                SQ_RESET: if (eng_done_i) begin
                    res_ppd_o <= eng_presence_i;
                    res_sd_o  <= eng_short_i;
                    state_q   <= SQ_IDLE;
                end
                SQ_BIT: if (eng_done_i) begin
                    res_sbr_o <= eng_rbit_i;
                    res_tsb_o <= 1'b0;
                    res_dir_o <= 1'b0;
                    state_q   <= SQ_IDLE;
                end
                SQ_WBYTE: if (eng_done_i) state_q <= SQ_IDLE;
                SQ_RBYTE: if (eng_done_i) begin
                    rbyte_vld_o <= 1'b1;
                    rbyte_o     <= eng_rbyte_i;
                    state_q     <= SQ_IDLE;
                end
                SQ_TRI_A: if (eng_done_i) begin
                    first_q     <= eng_rbit_i;
                    eng_req_o   <= 1'b1;
                    eng_wdata_o <= {{(BYTE_W-1){1'b0}}, 1'b1};
                    state_q     <= SQ_TRI_B;
                end
                SQ_TRI_B: if (eng_done_i) begin
                    res_sbr_o   <= first_q;
                    res_tsb_o   <= eng_rbit_i;
                    res_dir_o   <= dir_now;
                    eng_req_o   <= 1'b1;
                    eng_wdata_o <= {{(BYTE_W-1){1'b0}}, dir_now};
                    state_q     <= SQ_TRI_W;
                end
                SQ_TRI_W: if (eng_done_i) state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != SQ_IDLE);
    assign eng_op_o = op_q;

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |-> busy_o); // R5
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !eng_done_i) |=> busy_o); // R5
    AST_ONE_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |=> !eng_req_o); // R5
    AST_BOTH_ONES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sbr_o && res_tsb_o) |-> res_dir_o); // R10
    AST_RBYTE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rbyte_vld_o |-> $past(eng_done_i)); // R9

endmodule

// File: rtl/owb_reg_file.sv
// Register file: configuration nibble, read-data byte, reset flag and
// read pointer, plus the combinational read-back multiplexer. A host
// pointer command on the same edge as a read-byte pointer move wins.
module owb_reg_file
    import owb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd_i,
    input  logic             rbyte_vld_i,
    input  byte_t            rbyte_i,
    input  byte_t            status_i,
    output logic             rst_flag_o,
    output logic [CFG_W-1:0] cfg_o,
    output byte_t            rdata_o
);

    rdptr_e ptr_q;
    byte_t  data_q;

    // register updates; host command handled last so it takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o      <= '0;
            ptr_q      <= RP_STATUS;
            data_q     <= '0;
            rst_flag_o <= 1'b1;
        end else begin
            if (rbyte_vld_i) begin
                data_q <= rbyte_i;
                ptr_q  <= RP_DATA;
            end
            if (cmd_i.vld) begin
                case (cmd_i.kind)
                    K_DEVRST: begin
                        cfg_o      <= '0;
                        rst_flag_o <= 1'b1;
                        ptr_q      <= RP_STATUS;
                    end
                    K_SETPTR: begin
                        if (cmd_i.prm == SEL_STATUS) begin
                            ptr_q <= RP_STATUS;
                            rst_flag_o <= 1'b0;
                        end else if (cmd_i.prm == SEL_DATA) begin
                            ptr_q <= RP_DATA;
                            rst_flag_o <= 1'b0;
                        end else if (cmd_i.prm == SEL_CFG) begin
                            ptr_q <= RP_CFG;
                            rst_flag_o <= 1'b0;
                        end
                    end
                    K_WCFG: begin
                        if (cfg_ok(cmd_i.prm)) begin
                            cfg_o      <= cmd_i.prm[CFG_W-1:0];
                            ptr_q      <= RP_CFG;
                            rst_flag_o <= 1'b0;
                        end
                    end
                    K_BUSRST, K_BIT, K_WBYTE, K_RBYTE, K_TRIP: begin
                        ptr_q      <= RP_STATUS;
                        rst_flag_o <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // read-back of the selected register
    always_comb begin
        case (ptr_q)
            RP_DATA: rdata_o = data_q;
            RP_CFG:  rdata_o = {{(BYTE_W-CFG_W){1'b0}}, cfg_o};
            default: rdata_o = status_i;
        endcase
    end

    AST_CFG_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(cmd_i.vld && ((cmd_i.kind == K_WCFG && cfg_ok(cmd_i.prm)) ||
                                                cmd_i.kind == K_DEVRST))); // R4
    AST_RST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_flag_o) |-> $past(cmd_i.vld && cmd_i.kind == K_DEVRST)); // R2

endmodule

// File: rtl/owb_cmd_proc.sv
// Top level of the 1-Wire bridge command processor: connects the host
// byte decoder, the bus sequencer and the register file and assembles
// the status byte. Assumes one byte per host strobe and an external
// bit-level engine with a request/done handshake.
module owb_cmd_proc
    import owb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_valid,
    input  logic [7:0] host_byte,
    output logic [7:0] host_rdata,
    output logic       eng_req,
    output logic [1:0] eng_op,
    output logic [7:0] eng_wdata,
    input  logic       eng_done,
    input  logic       eng_rbit,
    input  logic [7:0] eng_rbyte,
    input  logic       eng_presence,
    input  logic       eng_short,
    input  logic       bus_level,
    output logic       cfg_active_pullup,
    output logic       cfg_strong_pullup,
    output logic       cfg_high_speed
);

    cmd_t             cmd;
    logic             busy;
    logic             ppd, sd, sbr, tsb, dir;
    logic             rbyte_vld;
    byte_t            rbyte;
    logic             rst_flag;
    logic [CFG_W-1:0] cfg;
    byte_t            status;

    owb_host_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (host_valid),
        .in_byte  (host_byte),
        .busy     (busy),
        .cmd_o    (cmd)
    );

    owb_bus_sequencer u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_i          (cmd),
        .busy_o         (busy),
        .eng_req_o      (eng_req),
        .eng_op_o       (eng_op),
        .eng_wdata_o    (eng_wdata),
        .eng_done_i     (eng_done),
        .eng_rbit_i     (eng_rbit),
        .eng_rbyte_i    (eng_rbyte),
        .eng_presence_i (eng_presence),
        .eng_short_i    (eng_short),
        .res_ppd_o      (ppd),
        .res_sd_o       (sd),
        .res_sbr_o      (sbr),
        .res_tsb_o      (tsb),
        .res_dir_o      (dir),
        .rbyte_vld_o    (rbyte_vld),
        .rbyte_o        (rbyte)
    );

    // status byte packing: dir, tsb, sbr, reset flag, level, short, presence, busy
    assign status = {dir, tsb, sbr, rst_flag, bus_level, sd, ppd, busy};

    owb_reg_file u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .rbyte_vld_i (rbyte_vld),
        .rbyte_i     (rbyte),
        .status_i    (status),
        .rst_flag_o  (rst_flag),
        .cfg_o       (cfg),
        .rdata_o     (host_rdata)
    );

    assign cfg_active_pullup = cfg[0];
    assign cfg_strong_pullup = cfg[2];
    assign cfg_high_speed    = cfg[3];

    AST_BUSY_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !busy) |-> 1'b0 == eng_req); // R5

endmodule

// File: tb/owb_cmd_proc_tb.sv
// Bench for owb_cmd_proc: a timed engine model, sweeps of the
// configuration and pointer codes, every triplet case and the
// same-edge collisions.
module owb_cmd_proc_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_valid = 1'b0;
    logic [7:0] host_byte = '0;
    logic [7:0] host_rdata;
    logic       eng_req;
    logic [1:0] eng_op;
    logic [7:0] eng_wdata;
    logic       eng_done = 1'b0;
    logic       eng_rbit = 1'b0;
    logic [7:0] eng_rbyte = '0;
    logic       eng_presence = 1'b0;
    logic       eng_short = 1'b0;
    logic       bus_level = 1'b0;
    logic       cfg_active_pullup, cfg_strong_pullup, cfg_high_speed;

    always #5 clk = ~clk;

    owb_cmd_proc dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
        .host_rdata(host_rdata), .eng_req(eng_req), .eng_op(eng_op),
        .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_rbit(eng_rbit),
        .eng_rbyte(eng_rbyte), .eng_presence(eng_presence), .eng_short(eng_short),
        .bus_level(bus_level), .cfg_active_pullup(cfg_active_pullup),
        .cfg_strong_pullup(cfg_strong_pullup), .cfg_high_speed(cfg_high_speed)
    );

    // engine model state
    int         lat = 4;
    int         cnt = 0;
    int         op_n = 0;
    int         cur_idx = 0;
    logic [1:0] op_log [8];
    logic [7:0] wd_log [8];
    logic       resp_bit [8];
    logic [7:0] resp_byte = '0;
    logic       resp_pres = 1'b0;
    logic       resp_short = 1'b0;

    // expected state
    logic       e_ppd = 0, e_sd = 0, e_sbr = 0, e_tsb = 0, e_dir = 0, e_rst = 1;
    logic [3:0] e_cfg = '0;
    logic [7:0] e_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // engine model: answers each request after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    eng_done     = 1'b1;
                    eng_rbit     = resp_bit[cur_idx];
                    eng_rbyte    = resp_byte;
                    eng_presence = resp_pres;
                    eng_short    = resp_short;
                end
            end
            if (eng_req) begin
                cur_idx = (op_n < 8) ? op_n : 7;
                op_log[cur_idx] = eng_op;
                wd_log[cur_idx] = eng_wdata;
                op_n = op_n + 1;
                cnt = lat;
            end
        end
    end

    function automatic logic [7:0] exp_st();
        return {e_dir, e_tsb, e_sbr, e_rst, bus_level, e_sd, e_ppd, 1'b0};
    endfunction

    function automatic logic exp_dir(input logic a, input logic b, input logic p);
        if (a ^ b) return a;
        return a | p;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        host_valid = 1'b1;
        host_byte  = b;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (cnt == 0 && !eng_req) q++;
            else q = 0;
        end
    endtask

    task automatic set_ptr(input logic [7:0] code);
        send_byte(8'hE1);
        send_byte(code);
        if (code == 8'hF0 || code == 8'hE1 || code == 8'hC3) e_rst = 0;
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 8; i++) resp_bit[i] = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", host_rdata, 8'h10);
        chk("R1 cfg pins", {5'd0, cfg_high_speed, cfg_strong_pullup, cfg_active_pullup}, 8'h00);
        chk("R1 no request", {7'd0, eng_req}, 8'h00);

        // R12 logic level tracks bus_level
        bus_level = 1'b1;
        #1 chk("R12 level high", host_rdata, 8'h18);
        bus_level = 1'b0;
        #1 chk("R12 level low", host_rdata, 8'h10);

        // R4 sweep of every configuration parameter
        for (int p = 0; p < 256; p++) begin
            logic [7:0] pb = p[7:0];
            send_byte(8'hD2);
            send_byte(pb);
            if (pb[7:4] == ~pb[3:0]) begin
                e_cfg = pb[3:0];
                e_rst = 0;
                chk("R4 readback", host_rdata, {4'd0, e_cfg});
            end
            chk("R4 pins", {5'd0, cfg_high_speed, cfg_strong_pullup, cfg_active_pullup},
                {5'd0, e_cfg[3], e_cfg[2], e_cfg[0]});
            set_ptr(8'hC3);
            chk("R4 register", host_rdata, {4'd0, e_cfg});
        end

        // R6 bus reset with presence / short combinations, R5 busy
        for (int k = 0; k < 2; k++) begin
            resp_pres = (k == 0);
            resp_short = (k == 1);
            lat = 5;
            op_n = 0;
            send_byte(8'hB4);
            chk("R5 busy set", host_rdata & 8'h01, 8'h01);
            wait_quiet();
            e_ppd = resp_pres;
            e_sd = resp_short;
            chk("R6 op", {6'd0, op_log[0]}, 8'h00);
            chk("R6 count", op_n[7:0], 8'd1);
            chk("R6 status", host_rdata, exp_st());
            chk("R5 busy clear", host_rdata & 8'h01, 8'h00);
        end

        // R7 single bit: every written value and read result
        for (int pb = 0; pb < 2; pb++) begin
            for (int rb = 0; rb < 2; rb++) begin
                resp_bit[0] = rb[0];
                op_n = 0;
                lat = 3;
                send_byte(8'h87);
                send_byte({pb[0], 7'd0});
                wait_quiet();
                e_sbr = rb[0];
                e_tsb = 0;
                e_dir = 0;
                chk("R7 op", {6'd0, op_log[0]}, 8'h01);
                chk("R7 wbit", {7'd0, wd_log[0][0]}, {7'd0, pb[0]});
                chk("R7 status", host_rdata, exp_st());
            end
        end

        // R8 write byte patterns
        for (int i = 0; i < 5; i++) begin
            logic [7:0] b = 8'h33 * i[7:0] + 8'h5A;
            op_n = 0;
            send_byte(8'hA5);
            send_byte(b);
            wait_quiet();
            chk("R8 op", {6'd0, op_log[0]}, 8'h02);
            chk("R8 data", wd_log[0], b);
            chk("R8 count", op_n[7:0], 8'd1);
        end

        // R9 read byte patterns
        for (int i = 0; i < 4; i++) begin
            resp_byte = 8'h3C ^ (8'h55 * i[7:0]);
            op_n = 0;
            send_byte(8'h96);
            wait_quiet();
            e_data = resp_byte;
            chk("R9 op", {6'd0, op_log[0]}, 8'h03);
            chk("R9 data via pointer", host_rdata, e_data);
        end

        // R10 every triplet case, R13 bus command selects status
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                for (int p = 0; p < 2; p++) begin
                    resp_bit[0] = a[0];
                    resp_bit[1] = b[0];
                    resp_bit[2] = 1'b0;
                    op_n = 0;
                    lat = 2 + a + b;
                    send_byte(8'h78);
                    send_byte({p[0], 7'd0});
                    wait_quiet();
                    e_sbr = a[0];
                    e_tsb = b[0];
                    e_dir = exp_dir(a[0], b[0], p[0]);
                    chk("R10 count", op_n[7:0], 8'd3);
                    chk("R10 ops", {op_log[0], op_log[1], op_log[2], 2'b00}, 8'b01010100);
                    chk("R10 slot writes", {5'd0, wd_log[0][0], wd_log[1][0], wd_log[2][0]},
                        {5'd0, 1'b1, 1'b1, e_dir});
                    chk("R10 R13 status", host_rdata, exp_st());
                end
            end
        end

        // R3 sweep of every pointer code
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb = c[7:0];
            set_ptr(8'hF0);
            set_ptr(cb);
            if (cb == 8'hE1) v = e_data;
            else if (cb == 8'hC3) v = {4'd0, e_cfg};
            else v = exp_st();
            chk("R3 pointer", host_rdata, v);
        end

        // R2 device reset
        send_byte(8'hF0);
        e_cfg = 0; e_rst = 1;
        e_ppd = 0; e_sd = 0; e_sbr = 0; e_tsb = 0; e_dir = 0;
        chk("R2 status", host_rdata, exp_st());
        chk("R2 cfg pins", {5'd0, cfg_high_speed, cfg_strong_pullup, cfg_active_pullup}, 8'h00);
        set_ptr(8'hF0);
        chk("R2 flag cleared", host_rdata, exp_st());

        // R11 unknown opcode takes no parameter
        op_n = 0;
        lat = 3;
        send_byte(8'h00);
        send_byte(8'hB4);
        wait_quiet();
        chk("R11 unknown opcode", op_n[7:0], 8'd1);

        // R11 bytes while busy are dropped, except set-pointer
        op_n = 0;
        lat = 12;
        resp_byte = 8'hA7;
        send_byte(8'h96);
        send_byte(8'hD2);
        send_byte(8'h1E);
        send_byte(8'hB4);
        wait_quiet();
        e_data = 8'hA7;
        chk("R11 one engine op", op_n[7:0], 8'd1);
        set_ptr(8'hC3);
        chk("R11 cfg kept", host_rdata, 8'h00);

        // R11 byte on the done edge is dropped; one cycle later accepted
        op_n = 0;
        lat = 6;
        @(negedge clk); host_valid = 1'b1; host_byte = 8'hB4;   // a
        @(negedge clk); host_valid = 1'b0;                      // a+1
        repeat (5) @(negedge clk);                              // a+6
        @(negedge clk); host_valid = 1'b1; host_byte = 8'hD2;   // a+7, done edge
        @(negedge clk); host_valid = 1'b1; host_byte = 8'h1E;   // a+8
        @(negedge clk); host_valid = 1'b0;
        wait_quiet();
        set_ptr(8'hC3);
        chk("R11 done-edge byte dropped", host_rdata, 8'h00);
        send_byte(8'hD2);
        send_byte(8'h3C);
        e_cfg = 4'hC;
        chk("R11 next byte accepted", host_rdata, 8'h0C);

        // R13 host pointer collides with read-byte pointer move
        send_byte(8'hD2);
        send_byte(8'h96);
        e_cfg = 4'h6;
        resp_byte = 8'hC7;
        lat = 8;
        @(negedge clk); host_valid = 1'b1; host_byte = 8'h96;   // a
        @(negedge clk); host_valid = 1'b1; host_byte = 8'hE1;   // a+1
        @(negedge clk); host_valid = 1'b0;                      // a+2
        repeat (7) @(negedge clk);                              // a+9
        @(negedge clk); host_valid = 1'b1; host_byte = 8'hC3;   // a+10
        @(negedge clk); host_valid = 1'b0;
        chk("R13 host pointer wins", host_rdata, {4'd0, e_cfg});
        wait_quiet();
        set_ptr(8'hE1);
        chk("R9 byte still captured", host_rdata, 8'hC7);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R5 actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule